// File: doc/BRIEF.md
# DRAM Refresh Scheduler and Access Sequencer

This block connects a host memory port to a DRAM whose address pins are shared between row and column. Each accepted host request is split into a row half and a column half. The row half is driven while the row strobe falls, and the column half while the column strobe falls, with a write-enable strobe for writes. All strobes are active-low. The timing of the strobes is set by three parameters counted in clock cycles: the row strobe's active time, the row-to-column delay and the precharge time.

A down-counting interval timer asks for a refresh each time it reaches zero. The sequencer serves a due refresh before any host request. While a refresh is due or running, `ready_o` stays low. Expiries that happen while the sequencer is busy are counted, so a refresh that has to wait is served later and not lost.

Two refresh styles are selectable. The RAS-only style drives an internal row counter on the address pins and pulses only the row strobe. The CAS-before-RAS style drops the column strobe first and leaves row selection to the DRAM. A hidden mode chains a refresh onto the end of a host cycle and restarts the interval timer at that point.

Top module: `dref_ctrl`

## Requirements
- R1: While `rst_ni` is low, `ras_no`, `cas_no` and `we_no` are all high. The row counter and the interval timer reset to zero, so the first refresh falls due in the first cycle after reset.
- R2: A host address carries the row in its upper ROW_W bits and the column in its lower ROW_W bits. The row is on `dram_addr_o` when `ras_no` falls, and the column is there when `cas_no` falls. `we_no` is low in the column phase exactly when `we_i` was 1 at acceptance.
- R3: A request is taken on a clock edge where `req_i` and `ready_o` are both high. In every access and refresh, `ras_no` stays low for exactly T_RAS cycles. In a host cycle, `cas_no` falls T_RCD cycles after `ras_no`. `ras_no` stays high for at least T_RP cycles between low periods.
- R4: The timer expires once every `interval_i`+1 cycles. Each expiry inserts a refresh, and `ready_o` stays low until that refresh ends.
- R5: When a refresh is due in the same cycle as a host request, the refresh is started first and `ready_o` is low in that cycle.
- R6: With `mode_cbr_i`=0 (RAS-only), a refresh drives the row counter on `dram_addr_o` and pulses only `ras_no`. `cas_no` stays high throughout.
- R7: The row counter steps by one after each RAS-only refresh and wraps from 2^ROW_W-1 to 0. A CAS-before-RAS refresh leaves it unchanged.
- R8: With `mode_cbr_i`=1, `cas_no` falls T_RCD cycles before `ras_no`, and both then stay low together for T_RAS cycles.
- R9: If `hidden_en_i`=1 when a host column phase ends, a refresh follows after T_RP cycles of precharge, before `ready_o` rises again. The interval timer restarts at that point.
- R10: Expiries that occur while the sequencer is busy are counted, up to 2^PEND_W-1. Each counted expiry later receives its own refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| interval_i | input | TMR_W | Refresh interval; the period is this value plus one cycle |
| mode_cbr_i | input | 1 | 1 selects CAS-before-RAS refresh, 0 selects RAS-only refresh |
| hidden_en_i | input | 1 | 1 chains a refresh onto the host cycle that is ending |
| req_i | input | 1 | Host access request |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | 2*ROW_W | Flat host address, with the row in the upper half |
| ready_o | output | 1 | High when a host request can be taken this cycle |
| dram_addr_o | output | ROW_W | Multiplexed DRAM address |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write strobe, active low |

## Verification
The hardest condition to reach from the ports is a backlog of more than one pending refresh. To build one, the bench sets an interval shorter than a refresh cycle, lets several expiries pile up, and then raises the interval so the backlog can drain. It then compares the number of refreshes seen against the expiries it predicts. The refresh-first case is reached by holding a request through reset, because the first expiry is known to land on the first clock after reset. Timer restart is checked by placing a hidden refresh just before a scheduled expiry and measuring the gap to the next refresh.

// File: rtl/dref_pkg.sv
package dref_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HROW,
    ST_HCOL,
    ST_PRE,
    ST_RCAS,
    ST_RRAS
  } dref_st_e;
endpackage

// File: rtl/dref_timer.sv
module dref_timer #(
  parameter int TMR_W  = 16,
  parameter int PEND_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TMR_W-1:0] interval_i,
  input  logic             restart_i,
  input  logic             consume_i,
  output logic             due_o
);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic [TMR_W-1:0]  cnt_q;
  logic [PEND_W-1:0] pend_q;
  logic              expire, inc, dec;

  assign expire = (cnt_q == '0);
  // a restart covers the expiry it coincides with
  assign inc    = expire && !restart_i;
  assign dec    = consume_i && ((pend_q != '0) || inc);
  assign due_o  = expire || (pend_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (restart_i || expire) begin
      cnt_q <= interval_i;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else if (inc && !dec) begin
      if (pend_q != PEND_MAX) pend_q <= pend_q + 1'b1;
    end else if (dec && !inc) begin
      pend_q <= pend_q - 1'b1;
    end
  end

  // R9
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> cnt_q == $past(interval_i));

  // R10
  pend_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc && !consume_i && pend_q != PEND_MAX) |=> pend_q == $past(pend_q) + 1'b1);

  // R10
  pend_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (consume_i && !inc && pend_q != '0) |=> pend_q == $past(pend_q) - 1'b1);
endmodule

// File: rtl/dref_rowctr.sv
module dref_rowctr #(
  parameter int ROW_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [ROW_W-1:0] row_o
);
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    row_q <= '0;
    else if (adv_i) row_q <= row_q + 1'b1;
  end

  assign row_o = row_q;

  // R7
  row_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> row_q == $past(row_q) + ROW_W'(1));

  // R7
  row_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(row_q));
endmodule

// File: rtl/dref_seq.sv
module dref_seq
  import dref_pkg::*;
#(
  parameter int ROW_W = 10,
  parameter int T_RAS = 4,
  parameter int T_RP  = 2,
  parameter int T_RCD = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               due_i,
  input  logic               mode_cbr_i,
  input  logic               hidden_en_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [2*ROW_W-1:0] addr_i,
  input  logic [ROW_W-1:0]   ref_row_i,
  output logic               ready_o,
  output logic               consume_o,
  output logic               restart_o,
  output logic               adv_o,
  output logic [ROW_W-1:0]   dram_addr_o,
  output logic               ras_no,
  output logic               cas_no,
  output logic               we_no
);
  localparam int T_COL = T_RAS - T_RCD;
  localparam int T_MAX = (T_RAS > T_RP) ? T_RAS : T_RP;
  localparam int CNT_W = $clog2(T_MAX + 1);

  dref_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hid_q, hid_d, cbr_q, cbr_d, we_q, we_d;
  logic [ROW_W-1:0] row_q, row_d, col_q, col_d;
  logic             last;

  function automatic logic [CNT_W-1:0] ld(dref_st_e s);
    case (s)
      ST_HROW: return CNT_W'(T_RCD - 1);
      ST_HCOL: return CNT_W'(T_COL - 1);
      ST_PRE:  return CNT_W'(T_RP - 1);
      ST_RCAS: return CNT_W'(T_RCD - 1);
      ST_RRAS: return CNT_W'(T_RAS - 1);
      default: return '0;
    endcase
  endfunction

  assign last    = (cnt_q == '0);
  assign ready_o = (st_q == ST_IDLE) && !due_i;

  always_comb begin
    st_d      = st_q;
    hid_d     = hid_q;
    cbr_d     = cbr_q;
    we_d      = we_q;
    row_d     = row_q;
    col_d     = col_q;
    consume_o = 1'b0;
    restart_o = 1'b0;
    adv_o     = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (due_i) begin
          consume_o = 1'b1;
          cbr_d     = mode_cbr_i;
          st_d      = mode_cbr_i ? ST_RCAS : ST_RRAS;
        end else if (req_i) begin
          st_d  = ST_HROW;
          we_d  = we_i;
          row_d = addr_i[2*ROW_W-1:ROW_W];
          col_d = addr_i[ROW_W-1:0];
        end
      end
      ST_HROW: if (last) st_d = ST_HCOL;
      ST_HCOL: begin
        if (last) begin
          st_d  = ST_PRE;
          hid_d = hidden_en_i;
          if (hidden_en_i) begin
            restart_o = 1'b1;
            consume_o = 1'b1;
          end
        end
      end
      ST_PRE: begin
        if (last) begin
          if (hid_q) begin
            hid_d = 1'b0;
            cbr_d = mode_cbr_i;
            st_d  = mode_cbr_i ? ST_RCAS : ST_RRAS;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      ST_RCAS: if (last) st_d = ST_RRAS;
      ST_RRAS: begin
        if (last) begin
          st_d  = ST_PRE;
          adv_o = !cbr_q;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (st_d != st_q)     cnt_d = ld(st_d);
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    else                  cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      hid_q <= 1'b0;
      cbr_q <= 1'b0;
      we_q  <= 1'b0;
      row_q <= '0;
      col_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      hid_q <= hid_d;
      cbr_q <= cbr_d;
      we_q  <= we_d;
      row_q <= row_d;
      col_q <= col_d;
    end
  end

  always_comb begin
    ras_no = !(st_q == ST_HROW || st_q == ST_HCOL || st_q == ST_RRAS);
    cas_no = !(st_q == ST_HCOL || st_q == ST_RCAS || (st_q == ST_RRAS && cbr_q));
    we_no  = !(st_q == ST_HCOL && we_q);
    case (st_q)
      ST_HROW: dram_addr_o = row_q;
      ST_HCOL: dram_addr_o = col_q;
      ST_RRAS: dram_addr_o = cbr_q ? '0 : ref_row_i;
      default: dram_addr_o = '0;
    endcase
  end

  // R5
  refwin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && due_i) |=> (st_q == ST_RCAS || st_q == ST_RRAS));

  // R3
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |=> st_q == ST_HROW);

  // R8
  cbr_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_no) && !cas_no) |-> cbr_q);
endmodule

// File: rtl/dref_ctrl.sv
module dref_ctrl #(
  parameter int ROW_W  = 10,
  parameter int TMR_W  = 16,
  parameter int PEND_W = 4,
  parameter int T_RAS  = 4,
  parameter int T_RP   = 2,
  parameter int T_RCD  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [TMR_W-1:0]   interval_i,
  input  logic               mode_cbr_i,
  input  logic               hidden_en_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [2*ROW_W-1:0] addr_i,
  output logic               ready_o,
  output logic [ROW_W-1:0]   dram_addr_o,
  output logic               ras_no,
  output logic               cas_no,
  output logic               we_no
);
  logic             due, consume, restart, adv;
  logic [ROW_W-1:0] ref_row;

  dref_timer #(.TMR_W(TMR_W), .PEND_W(PEND_W)) timer_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .interval_i (interval_i),
    .restart_i  (restart),
    .consume_i  (consume),
    .due_o      (due)
  );

  dref_rowctr #(.ROW_W(ROW_W)) rowctr_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv),
    .row_o  (ref_row)
  );

  dref_seq #(.ROW_W(ROW_W), .T_RAS(T_RAS), .T_RP(T_RP), .T_RCD(T_RCD)) seq_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .due_i       (due),
    .mode_cbr_i  (mode_cbr_i),
    .hidden_en_i (hidden_en_i),
    .req_i       (req_i),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .ref_row_i   (ref_row),
    .ready_o     (ready_o),
    .consume_o   (consume),
    .restart_o   (restart),
    .adv_o       (adv),
    .dram_addr_o (dram_addr_o),
    .ras_no      (ras_no),
    .cas_no      (cas_no),
    .we_no       (we_no)
  );
endmodule

// File: tb/dref_ctrl_tb.sv
module dref_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W  = 3;
  localparam int TMR_W  = 8;
  localparam int T_RAS  = 4;
  localparam int T_RP   = 2;
  localparam int T_RCD  = 2;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic [TMR_W-1:0]   interval_i = 8'd255;
  logic               mode_cbr_i = 1'b0;
  logic               hidden_en_i = 1'b0;
  logic               req_i = 1'b0;
  logic               we_i = 1'b0;
  logic [2*ROW_W-1:0] addr_i = '0;
  logic               ready_o;
  logic [ROW_W-1:0]   dram_addr_o;
  logic               ras_no, cas_no, we_no;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dref_ctrl #(.ROW_W(ROW_W), .TMR_W(TMR_W), .PEND_W(4), .T_RAS(T_RAS),
              .T_RP(T_RP), .T_RCD(T_RCD)) dut_i (.*);

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // strobe monitor, sampled at falling edges
  int cyc, low_len, high_len, cas_lead, fall_cyc;
  int n_host, n_ro, n_cbr, first_kind;
  int ref_fall_cyc, ref_rise_cyc, prev_ref_fall;
  logic ras_p, cas_p, cbr_m, saw_cas, host_we_n;
  logic [ROW_W-1:0] row_seen, col_seen, exp_row, host_row, host_col;

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      cyc = 0; low_len = 0; high_len = 100; cas_lead = 0; fall_cyc = 0;
      n_host = 0; n_ro = 0; n_cbr = 0; first_kind = 0;
      ref_fall_cyc = 0; ref_rise_cyc = 0; prev_ref_fall = 0;
      ras_p = 1'b1; cas_p = 1'b1; cbr_m = 1'b0; saw_cas = 1'b0;
      exp_row = '0;
    end else begin
      cyc++;
      if (ras_p && !ras_no) begin
        chk(high_len >= T_RP, "R3 precharge", high_len, T_RP);
        low_len = 1; fall_cyc = cyc; row_seen = dram_addr_o;
        cbr_m = !cas_no; saw_cas = 1'b0;
        if (cbr_m) chk(cas_lead == T_RCD, "R8 cas lead", cas_lead, T_RCD);
      end else if (!ras_no) begin
        low_len++;
      end
      if (!ras_no && !cas_no && cas_p && !cbr_m) begin
        saw_cas = 1'b1; col_seen = dram_addr_o; host_we_n = we_no;
        chk(low_len == T_RCD + 1, "R3 ras-to-cas", low_len - 1, T_RCD);
      end
      if (ras_no && !cas_no) cas_lead++;
      else if (ras_no) cas_lead = 0;
      if (!ras_p && ras_no) begin
        chk(low_len == T_RAS, "R3 ras width", low_len, T_RAS);
        high_len = 1;
        if (saw_cas) begin
          n_host++; host_row = row_seen; host_col = col_seen;
          if (first_kind == 0) first_kind = 1;
        end else begin
          if (first_kind == 0) first_kind = 2;
          prev_ref_fall = ref_fall_cyc; ref_fall_cyc = fall_cyc; ref_rise_cyc = cyc;
          if (cbr_m) n_cbr++;
          else begin
            n_ro++;
            chk(row_seen == exp_row, "R6 R7 refresh row", int'(row_seen), int'(exp_row));
            exp_row = exp_row + 1'b1;
          end
        end
      end else if (ras_no) begin
        high_len++;
      end
      ras_p = ras_no; cas_p = cas_no;
    end
  end

  typedef struct packed {
    logic             we;
    logic [5:0]       addr;
    logic             cbr;
    logic             hid;
    logic [ROW_W-1:0] erow;
    logic [ROW_W-1:0] ecol;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 6'b101_010, 1'b0, 1'b0, 3'd5, 3'd2},
    '{1'b0, 6'b000_000, 1'b0, 1'b1, 3'd0, 3'd0},
    '{1'b1, 6'b111_111, 1'b1, 1'b1, 3'd7, 3'd7},
    '{1'b0, 6'b011_100, 1'b1, 1'b0, 3'd3, 3'd4},
    '{1'b1, 6'b100_001, 1'b0, 1'b1, 3'd4, 3'd1},
    '{1'b0, 6'b010_110, 1'b0, 1'b0, 3'd2, 3'd6}
  };

  task automatic do_reset(input logic [TMR_W-1:0] iv);
    rst_ni = 1'b0; interval_i = iv; req_i = 1'b0; hidden_en_i = 1'b0; mode_cbr_i = 1'b0;
    repeat (3) begin
      @(negedge clk_i);
      chk(ras_no && cas_no && we_no, "R1 strobes idle in reset",
          int'({ras_no, cas_no, we_no}), 7);
    end
    #1 rst_ni = 1'b1;
  endtask

  task automatic host_access(input logic w, input logic [5:0] a);
    @(negedge clk_i);
    while (!ready_o) @(negedge clk_i);
    req_i = 1'b1; we_i = w; addr_i = a;
    @(negedge clk_i);
    req_i = 1'b0;
    while (!ready_o) @(negedge clk_i);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // Phase A: request held through reset; first expiry must win (R5, R4)
    rst_ni = 1'b0; req_i = 1'b1; we_i = 1'b0; addr_i = 6'b110_011;
    repeat (3) begin
      @(negedge clk_i);
      chk(ras_no && cas_no && we_no, "R1 strobes idle in reset",
          int'({ras_no, cas_no, we_no}), 7);
    end
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!ready_o, "R5 ready low while refresh due", int'(ready_o), 0);
    chk(!ras_no && cas_no, "R5 refresh started before host", int'({ras_no, cas_no}), 1);
    while (!ready_o) @(negedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0;
    while (!ready_o) @(negedge clk_i);
    #1;
    chk(first_kind == 2, "R4 R5 refresh precedes held request", first_kind, 2);
    chk(n_host == 1, "R3 held request served", n_host, 1);
    chk(host_row == 3'd6 && host_col == 3'd3, "R2 held request address",
        int'({host_row, host_col}), 8'o63);

    // Phase B: table of host accesses
    foreach (VECS[i]) begin
      automatic int h0 = n_host;
      automatic int r0 = n_ro;
      automatic int c0 = n_cbr;
      mode_cbr_i = VECS[i].cbr;
      hidden_en_i = VECS[i].hid;
      host_access(VECS[i].we, VECS[i].addr);
      chk(n_host == h0 + 1, "R3 one host cycle", n_host - h0, 1);
      chk(host_row == VECS[i].erow, "R2 row half", int'(host_row), int'(VECS[i].erow));
      chk(host_col == VECS[i].ecol, "R2 column half", int'(host_col), int'(VECS[i].ecol));
      chk(host_we_n == !VECS[i].we, "R2 write strobe", int'(host_we_n), int'(!VECS[i].we));
      chk(n_ro - r0 == int'(VECS[i].hid && !VECS[i].cbr), "R9 R6 hidden RAS-only refresh",
          n_ro - r0, int'(VECS[i].hid && !VECS[i].cbr));
      chk(n_cbr - c0 == int'(VECS[i].hid && VECS[i].cbr), "R9 R8 hidden CBR refresh",
          n_cbr - c0, int'(VECS[i].hid && VECS[i].cbr));
    end
    hidden_en_i = 1'b0; mode_cbr_i = 1'b0;

    // Phase C: timer restart by hidden refresh, then exact period (R9, R4)
    do_reset(8'd30);
    repeat (10) @(negedge clk_i);
    hidden_en_i = 1'b1;
    host_access(1'b0, 6'b001_001);
    hidden_en_i = 1'b0;
    begin
      automatic int r0 = n_ro;
      automatic int hid_rise = ref_rise_cyc;
      automatic int gap;
      chk(r0 == 2, "R9 hidden refresh seen", r0, 2);
      while (n_ro == r0) @(negedge clk_i);
      #1;
      gap = ref_fall_cyc - hid_rise;
      chk(gap >= 22 && gap <= 30, "R9 timer restarted", gap, 25);
      while (n_ro == r0 + 1) @(negedge clk_i);
      #1;
      chk(ref_fall_cyc - prev_ref_fall == 31, "R4 refresh period",
          ref_fall_cyc - prev_ref_fall, 31);
    end

    // Phase D: backlog of expiries, then drain (R10, R7 wrap)
    do_reset(8'd3);
    repeat (40) @(negedge clk_i);
    interval_i = 8'd255;
    repeat (160) @(negedge clk_i);
    #1;
    chk(n_ro >= 10 && n_ro <= 12, "R10 deferred refreshes kept", n_ro, 11);
    chk(n_ro >= 9, "R7 row counter wrapped", n_ro, 11);

    // Phase E: CBR refresh leaves row counter (R8, R7)
    mode_cbr_i = 1'b1;
    interval_i = 8'd10;
    begin
      automatic int c0 = n_cbr;
      repeat (300) @(negedge clk_i);
      #1;
      chk(n_cbr > c0, "R8 timer CBR refreshes", n_cbr - c0, 1);
    end
    mode_cbr_i = 1'b0;
    begin
      automatic int r0 = n_ro;
      repeat (40) @(negedge clk_i);
      #1;
      chk(n_ro > r0, "R7 RAS-only resumes after CBR", n_ro - r0, 1);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule